// File: doc/BRIEF.md
# Color Palette Address Front-End

This block sits in front of a 256-entry color look-up table in a video palette device. Each clock it takes a pixel word and a plane-count code, clears the pixel bits the read mask turns off, and fills the address bits above the active planes from a page register. In this way one table can hold several small palettes. The table entry found at that address comes out on a registered output one clock later.

A small host port gives access to the registers. It has four slots: an index register, an indirect data window, the read mask, and palette data. The indirect window reaches the page register, a mode-control register, a fixed identity value, and a software-reset strobe. Palette data goes through at either 8-bit or 6-bit width. An external pin sets the width unless a control bit overrides the pin. The palette location that host palette accesses use is the current index register value.

Top module: `pal_front`

## Requirements
- R1: After reset the index register reads 0x00, the read mask reads 0xFF, the page register reads 0x00, the mode-control register reads 0x00, and `width8` follows `pin_8n6`.
- R2: With `plane_sel` = 3 (eight planes), every lookup address bit is the pixel bit ANDed with the matching read-mask bit.
- R3: With `plane_sel` = 2, 1 or 0 (four, two or one planes), the low 4, 2 or 1 address bits are the masked pixel bits. Every higher bit comes from the same bit of the page register, and pixel bits at those positions have no effect.
- R4: Page bits are placed after masking, so a zero mask bit never clears a page-supplied address bit.
- R5: `lut_out` shows the table entry for the pixel and plane code sampled at a rising edge right after that edge. It holds until the next edge.
- R6: Host slots are `host_addr` 0 = index, 1 = indirect data, 2 = read mask, 3 = palette data. Indirect index 0x1C is the page register and index 0x1E is the mode-control register, both read/write.
- R7: Indirect index 0x3F always reads 0x26. Writes to it change nothing.
- R8: When mode-control bit 2 is 0, the data width follows `pin_8n6` (1 = 8-bit, 0 = 6-bit). When bit 2 is 1, bit 3 sets the width and the pin is ignored. `width8` shows the selected width one clock later.
- R9: In 6-bit width, a palette write stores host data bits 5..0 in entry bits 7..2 and zero in bits 1..0. A palette read returns the entry shifted right by two.
- R10: In 8-bit width, palette writes store and palette reads return all eight bits unchanged.
- R11: A write through the data slot while the index is 0xFF sets the mask to 0xFF and the page and mode-control registers to 0x00 at that edge. Palette contents are not changed.
- R12: Read data for a `host_rd` sampled at an edge is on `host_rdata` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | Host slot select |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, one clock after the strobe |
| pix_in | input | 8 | Pixel port bits |
| plane_sel | input | 2 | Active planes: 0=1, 1=2, 2=4, 3=8 |
| pin_8n6 | input | 1 | External width select, 1 = 8-bit |
| lut_out | output | 8 | Registered table entry |
| width8 | output | 1 | Registered selected data width |

## Verification
A wrong mask or page register shows up on `lut_out` one clock after the next lookup. It appears as an entry taken from the wrong table location, so each lookup is compared against a bench copy of the table contents. A corrupted mode-control register shows on `width8` one clock later. It also shows on the next palette read-back, which comes back shifted or not shifted when the other result is expected. A failed software reset stays hidden until the registers are read back or a masked lookup is made, so both are done right after the strobe.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    HA_INDEX = 2'd0,
    HA_DATA  = 2'd1,
    HA_MASK  = 2'd2,
    HA_PAL   = 2'd3
  } host_slot_e;

  localparam logic [REG_W-1:0] IDX_PAGE  = 8'h1C;
  localparam logic [REG_W-1:0] IDX_MODE  = 8'h1E;
  localparam logic [REG_W-1:0] IDX_ID    = 8'h3F;
  localparam logic [REG_W-1:0] IDX_SWRST = 8'hFF;
  localparam logic [REG_W-1:0] ID_VALUE  = 8'h26;

  localparam int MODE_OVR_BIT = 2;
  localparam int MODE_W8_BIT  = 3;
endpackage

// File: rtl/pal_regs.sv
module pal_regs
  import pal_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [1:0]       host_addr,
  input  logic [REG_W-1:0] host_wdata,
  output logic [PW-1:0]    mask_o,
  output logic [PW-1:0]    page_o,
  output logic [REG_W-1:0] index_o,
  output logic             width_ovr_o,
  output logic             width_sel_o,
  output logic [REG_W-1:0] reg_rdata_o
);
  logic [REG_W-1:0] mode_q;
  logic             data_wr;
  logic             sw_reset;
  logic [REG_W-1:0] ind_rdata;

  assign data_wr  = host_wr && (host_addr == HA_DATA);
  assign sw_reset = data_wr && (index_o == IDX_SWRST);

  always_ff @(posedge clk) begin
    if (rst) begin
      index_o <= '0;
      mask_o  <= '1;
      page_o  <= '0;
      mode_q  <= '0;
    end else if (sw_reset) begin
      mask_o  <= '1;
      page_o  <= '0;
      mode_q  <= '0;
    end else if (host_wr) begin
      unique case (host_addr)
        HA_INDEX: index_o <= host_wdata;
        HA_MASK:  mask_o  <= host_wdata[PW-1:0];
        HA_DATA: begin
          if (index_o == IDX_PAGE) page_o <= host_wdata[PW-1:0];
          if (index_o == IDX_MODE) mode_q <= host_wdata;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (index_o)
      IDX_PAGE: ind_rdata = REG_W'(page_o);
      IDX_MODE: ind_rdata = mode_q;
      IDX_ID:   ind_rdata = ID_VALUE;
      default:  ind_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata_o <= '0;
    end else if (host_rd) begin
      unique case (host_addr)
        HA_INDEX: reg_rdata_o <= index_o;
        HA_DATA:  reg_rdata_o <= ind_rdata;
        HA_MASK:  reg_rdata_o <= REG_W'(mask_o);
        default:  reg_rdata_o <= '0;
      endcase
    end
  end

  assign width_ovr_o = mode_q[MODE_OVR_BIT];
  assign width_sel_o = mode_q[MODE_W8_BIT];

  a_r7_id_fixed: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == HA_DATA && index_o == IDX_ID) |=> (reg_rdata_o == ID_VALUE));

  a_r11_swreset_defaults: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == HA_DATA && index_o == IDX_SWRST)
      |=> (mask_o == '1 && page_o == '0 && !width_ovr_o && !width_sel_o));

  a_r6_page_write: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == HA_DATA && index_o == IDX_PAGE)
      |=> (page_o == $past(host_wdata[PW-1:0])));
endmodule

// File: rtl/pal_addr_gen.sv
module pal_addr_gen #(
  parameter int PW    = 8,
  parameter int SEL_W = $clog2($clog2(PW) + 1)
) (
  input  logic [PW-1:0]    pix_i,
  input  logic [PW-1:0]    mask_i,
  input  logic [PW-1:0]    page_i,
  input  logic [SEL_W-1:0] plane_sel_i,
  output logic [PW-1:0]    addr_o
);
  localparam int CW = $clog2(PW) + 2;

  logic [CW-1:0] n_planes;
  assign n_planes = CW'(1) << plane_sel_i;

  for (genvar i = 0; i < PW; i++) begin : g_bit
    assign addr_o[i] = (CW'(i) >= n_planes) ? page_i[i] : (pix_i[i] & mask_i[i]);
  end

  always_comb begin
    if (n_planes < CW'(PW)) begin
      a_r4_top_from_page: assert (addr_o[PW-1] == page_i[PW-1]);
    end
  end
endmodule

// File: rtl/pal_ram.sv
module pal_ram #(
  parameter int AW = 8,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic          rb_en,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    ra_data <= mem[ra_addr];
  end

  always_ff @(posedge clk) begin
    if (rb_en) rb_data <= mem[rb_addr];
  end
endmodule

// File: rtl/pal_front.sv
module pal_front
  import pal_pkg::*;
#(
  parameter int PW    = 8,
  parameter int DW    = 8,
  parameter int SEL_W = $clog2($clog2(PW) + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [1:0]       host_addr,
  input  logic [DW-1:0]    host_wdata,
  output logic [DW-1:0]    host_rdata,
  input  logic [PW-1:0]    pix_in,
  input  logic [SEL_W-1:0] plane_sel,
  input  logic             pin_8n6,
  output logic [DW-1:0]    lut_out,
  output logic             width8
);
  localparam int SH = DW - 6;

  logic [PW-1:0]    mask, page, lut_addr;
  logic [REG_W-1:0] index, reg_rdata;
  logic             width_ovr, width_sel, width_now;
  logic             pal_we, pal_re;
  logic [DW-1:0]    pal_wdata, pal_rdata;
  logic             rd_pal_q, rd_w8_q;

  pal_regs #(.PW(PW)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .mask_o      (mask),
    .page_o      (page),
    .index_o     (index),
    .width_ovr_o (width_ovr),
    .width_sel_o (width_sel),
    .reg_rdata_o (reg_rdata)
  );

  pal_addr_gen #(.PW(PW), .SEL_W(SEL_W)) u_addr (
    .pix_i       (pix_in),
    .mask_i      (mask),
    .page_i      (page),
    .plane_sel_i (plane_sel),
    .addr_o      (lut_addr)
  );

  assign width_now = width_ovr ? width_sel : pin_8n6;
  assign pal_we    = host_wr && (host_addr == HA_PAL);
  assign pal_re    = host_rd && (host_addr == HA_PAL);
  assign pal_wdata = width_now ? host_wdata : (host_wdata << SH);

  pal_ram #(.AW(PW), .DW(DW)) u_ram (
    .clk     (clk),
    .we      (pal_we),
    .waddr   (index[PW-1:0]),
    .wdata   (pal_wdata),
    .ra_addr (lut_addr),
    .ra_data (lut_out),
    .rb_en   (pal_re),
    .rb_addr (index[PW-1:0]),
    .rb_data (pal_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      width8   <= 1'b0;
      rd_pal_q <= 1'b0;
      rd_w8_q  <= 1'b0;
    end else begin
      width8 <= width_now;
      if (host_rd) begin
        rd_pal_q <= pal_re;
        rd_w8_q  <= width_now;
      end
    end
  end

  assign host_rdata = rd_pal_q ? (rd_w8_q ? pal_rdata : (pal_rdata >> SH)) : reg_rdata;

  a_r8_pin_follow: assert property (@(posedge clk) disable iff (rst)
    !width_ovr |=> (width8 == $past(pin_8n6)));

  a_r8_override: assert property (@(posedge clk) disable iff (rst)
    width_ovr |=> (width8 == $past(width_sel)));
endmodule

// File: tb/test_pal_front.sv
module test_pal_front;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] host_rdata;
  logic [7:0] pix_in = 8'd0;
  logic [1:0] plane_sel = 2'd3;
  logic       pin_8n6 = 1'b1;
  logic [7:0] lut_out;
  logic       width8;

  int checks = 0, fails = 0;
  logic [7:0] mdl [256];
  logic [7:0] m_mask = 8'hFF, m_page = 8'h00;
  logic       done = 1'b0;

  always #2 clk = ~clk;

  pal_front i_pal_front (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .pix_in(pix_in), .plane_sel(plane_sel), .pin_8n6(pin_8n6),
    .lut_out(lut_out), .width8(width8)
  );

  function automatic logic [7:0] exp_addr(logic [7:0] p, logic [7:0] m,
                                          logic [7:0] pg, logic [1:0] s);
    logic [7:0] a;
    int n = 1 << s;
    for (int i = 0; i < 8; i++) a[i] = (i >= n) ? pg[i] : (p[i] & m[i]);
    return a;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic set_mask(input logic [7:0] m);
    wr(2'd2, m); m_mask = m;
  endtask

  task automatic set_page(input logic [7:0] p);
    wr(2'd0, 8'h1C); wr(2'd1, p); m_page = p;
  endtask

  task automatic lookup(input logic [7:0] p, input logic [1:0] s, output logic [7:0] d);
    @(negedge clk);
    pix_in = p; plane_sel = s;
    @(negedge clk);
    d = lut_out;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    logic [7:0] d, e, a, v;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state, R12 read timing
    rd(2'd0, d); check("R1 index reset", d, 8'h00);
    rd(2'd2, d); check("R1 R12 mask reset", d, 8'hFF);
    wr(2'd0, 8'h1C); rd(2'd1, d); check("R1 page reset", d, 8'h00);
    wr(2'd0, 8'h1E); rd(2'd1, d); check("R1 mode reset", d, 8'h00);
    @(negedge clk); check("R1 width follows pin", {7'd0, width8}, 8'h01);

    // R7 identity
    wr(2'd0, 8'h3F); rd(2'd1, d); check("R7 identity", d, 8'h26);
    wr(2'd1, 8'h55); rd(2'd1, d); check("R7 identity write ignored", d, 8'h26);

    // R6 indirect registers
    set_page(8'h5A); rd(2'd1, d); check("R6 page readback", d, 8'h5A);
    wr(2'd0, 8'h1E); wr(2'd1, 8'h0C); rd(2'd1, d); check("R6 mode readback", d, 8'h0C);
    wr(2'd1, 8'h00);
    set_page(8'h00);

    // R10 fill table in 8-bit width
    for (int i = 0; i < 256; i++) begin
      v = 8'($urandom);
      wr(2'd0, 8'(i)); wr(2'd3, v); mdl[i] = v;
    end
    for (int k = 0; k < 6; k++) begin
      a = 8'($urandom);
      wr(2'd0, a); rd(2'd3, d); check("R10 8-bit readback", d, mdl[a]);
    end

    // R2 eight planes
    for (int k = 0; k < 8; k++) begin
      a = 8'($urandom);
      lookup(a, 2'd3, d); check("R2 full planes", d, mdl[a]);
    end
    set_mask(8'h0F);
    lookup(8'hFF, 2'd3, d); check("R2 masked full planes", d, mdl[8'h0F]);

    // R4 page bits survive a zero mask
    set_mask(8'h00); set_page(8'hA5);
    lookup(8'hFF, 2'd0, d); check("R4 page after mask", d, mdl[8'hA4]);

    // R5 latency and hold
    set_mask(8'hFF); set_page(8'h00);
    lookup(8'h11, 2'd3, d); check("R5 one clock", d, mdl[8'h11]);
    @(negedge clk); pix_in = 8'h22;
    #1 check("R5 hold before edge", lut_out, mdl[8'h11]);
    @(negedge clk); check("R5 next entry", lut_out, mdl[8'h22]);

    // R3 random planes, masks and pages
    for (int k = 0; k < 150; k++) begin
      set_mask(8'($urandom)); set_page(8'($urandom));
      for (int j = 0; j < 3; j++) begin
        logic [1:0] s;
        a = 8'($urandom); s = 2'($urandom);
        e = mdl[exp_addr(a, m_mask, m_page, s)];
        lookup(a, s, d);
        check(s == 2'd3 ? "R2 random" : "R3 random planes", d, e);
      end
    end

    // R8 width selection
    wr(2'd0, 8'h1E); wr(2'd1, 8'h00);
    @(negedge clk); pin_8n6 = 1'b0;
    @(negedge clk); check("R8 pin low", {7'd0, width8}, 8'h00);
    pin_8n6 = 1'b1;
    @(negedge clk); check("R8 pin high", {7'd0, width8}, 8'h01);
    wr(2'd1, 8'h04);
    @(negedge clk); check("R8 override 6-bit", {7'd0, width8}, 8'h00);
    wr(2'd1, 8'h0C); pin_8n6 = 1'b0;
    @(negedge clk); check("R8 override 8-bit", {7'd0, width8}, 8'h01);

    // R9 6-bit path
    wr(2'd1, 8'h04); pin_8n6 = 1'b1;
    wr(2'd0, 8'h10); wr(2'd3, 8'hFF); mdl[8'h10] = 8'hFC;
    rd(2'd3, d); check("R9 6-bit readback", d, 8'h3F);
    wr(2'd0, 8'h20); wr(2'd3, 8'hEA); mdl[8'h20] = 8'hA8;
    rd(2'd3, d); check("R9 6-bit upper bits dropped", d, 8'h2A);
    set_mask(8'hFF); set_page(8'h00);
    lookup(8'h10, 2'd3, d); check("R9 stored left-aligned", d, 8'hFC);
    lookup(8'h20, 2'd3, d); check("R9 stored left-aligned", d, 8'hA8);

    // R11 software reset
    set_mask(8'h3C); set_page(8'h77);
    wr(2'd0, 8'h1E); wr(2'd1, 8'h0C);
    pin_8n6 = 1'b0;
    wr(2'd0, 8'hFF); wr(2'd1, 8'h00);
    rd(2'd2, d); check("R11 mask restored", d, 8'hFF);
    wr(2'd0, 8'h1C); rd(2'd1, d); check("R11 page cleared", d, 8'h00);
    wr(2'd0, 8'h1E); rd(2'd1, d); check("R11 mode cleared", d, 8'h00);
    check("R11 width back to pin", {7'd0, width8}, 8'h00);
    lookup(8'h20, 2'd3, d); check("R11 table kept", d, mdl[8'h20]);

    done = 1'b1;
    report();
  end
endmodule